// File: doc/BRIEF.md
# External Clock Fault Detector with Fallback Routing

This block watches an external high-frequency clock, from either a crystal or a bypassed oscillator, and treats it as faulty until it has produced an unbroken run of oscillations. The external clock is sampled in a reference clock domain. Each rising edge it shows there counts toward a qualification threshold. If the reference clock runs a programmable number of cycles with no external edge, the block declares a new fault. A faster external clock reaches the threshold in fewer reference cycles, because qualification counts edges and not time. A control bit can bypass the count so that the first edge qualifies the input.

Fault reporting uses sticky flags. Software clears a flag by writing a one to its clear strobe. The external flag comes up set after reset. It stays set after the fault condition goes away, and it can only be cleared once the condition is gone. A second, internal-oscillator flag is kept in the same way. A global flag collects both local flags, and software clears it separately. The interrupt-flag output follows the global flag. Nothing is signalled when a fault ends, so software has to poll.

Each clock consumer supplies a source-select code and gets back an effective code. When a consumer asks for the external source and the external flag or the global flag is set, the block returns the fallback code instead. All other codes pass through unchanged. The external clock period must be at least two reference clock periods.

Top module: `osc_fault_failover`

## Requirements
- R1: During and immediately after reset, the external fault flag and the global flag are set, the internal fault flag is clear, and every consumer selecting the external source (code 2) is given the fallback code (code 0).
- R2: The external fault flag is sticky. A write-1 on its clear strobe clears it only when the fault condition is absent. A clear while the condition is present leaves it set.
- R3: The fault condition ends on the GOOD_CNT-th external rising edge seen since the last reset or fault. An edge is detected three reference cycles after it is sampled.
- R4: If the reference clock runs more than `timeout_i` consecutive cycles with no detected external edge, the fault condition is set again and the edge count restarts from zero.
- R5: With `cnt_en_i` low, the first detected external edge ends the fault condition.
- R6: The internal fault flag is set by `int_fault_i` and stays set until a write-1 clear arrives in a cycle without `int_fault_i`.
- R7: The global flag is set in the cycle after either local flag is set. A write-1 on its clear strobe takes effect only when both local flags were already clear.
- R8: A consumer selecting code 2 is given code 0 while the external flag or the global flag is set. Codes 0, 1 and 3, and code 2 when neither flag is set, pass through unchanged.
- R9: The interrupt-flag output equals the global flag. It does not change when a fault condition ends.
- R10: A clear strobe that coincides with a new fault event leaves the external fault flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ext_clk_i | input | 1 | External clock being monitored |
| cnt_en_i | input | 1 | 1 = require GOOD_CNT edges, 0 = accept on first edge |
| timeout_i | input | TMO_W | Edge-free reference cycles tolerated |
| int_fault_i | input | 1 | Internal oscillator fault condition |
| clr_ext_i | input | 1 | Write-1 clear of external fault flag |
| clr_int_i | input | 1 | Write-1 clear of internal fault flag |
| clr_glob_i | input | 1 | Write-1 clear of global flag |
| sel_i | input | N_CONS*2 | Requested source code per consumer |
| eff_sel_o | output | N_CONS*2 | Effective source code per consumer |
| ext_flag_o | output | 1 | External fault flag |
| int_flag_o | output | 1 | Internal fault flag |
| glob_flag_o | output | 1 | Global fault flag |
| irq_o | output | 1 | Interrupt flag |

## Verification
The bench builds the block with GOOD_CNT of 8, an 8-bit timeout field and three consumers. This lets the qualification count, repeated timeouts and recovery all happen within a few hundred cycles. With a timeout of 20, the bench can drive external periods of 2, 4 and 6 reference cycles that qualify at different speeds, and a stopped clock that trips the timeout. The consumer mix covers a rerouted external request and a code that passes through.

// File: rtl/osc_fd_pkg.sv
package osc_fd_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_FALLBACK = 2'd0,
        SRC_SLOW     = 2'd1,
        SRC_EXT      = 2'd2,
        SRC_SPARE    = 2'd3
    } osc_src_e;

    typedef struct packed {
        logic ext_f;
        logic int_f;
        logic glob_f;
    } fd_flags_t;

    function automatic osc_src_e route_src(input osc_src_e req, input logic fail);
        if (req == SRC_EXT && fail)
            return SRC_FALLBACK;
        return req;
    endfunction

endpackage

// File: rtl/osc_fd_edge_det.sv
module osc_fd_edge_det (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic rise_o
);
    logic [2:0] smp_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            smp_q <= '0;
        else
            smp_q <= {smp_q[1:0], async_i};
    end

    assign rise_o = smp_q[1] & ~smp_q[2];
endmodule

// File: rtl/osc_fd_monitor.sv
module osc_fd_monitor #(
    parameter int GOOD_CNT = 4096,
    parameter int TMO_W    = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             rise_i,
    input  logic             cnt_en_i,
    input  logic [TMO_W-1:0] timeout_i,
    output logic             cond_o
);
    localparam int GW = $clog2(GOOD_CNT + 1);
    localparam logic [GW-1:0] GOOD_LAST = GW'(GOOD_CNT - 1);

    logic [GW-1:0]    good_q;
    logic [TMO_W-1:0] idle_q;
    logic             cond_q;
    logic             expire;

    assign expire = !rise_i && (idle_q >= timeout_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            idle_q <= '0;
            good_q <= '0;
            cond_q <= 1'b1;
        end else if (expire) begin
            idle_q <= '0;
            good_q <= '0;
            cond_q <= 1'b1;
        end else begin
            idle_q <= rise_i ? '0 : idle_q + 1'b1;
            if (rise_i && cond_q) begin
                if (!cnt_en_i || good_q == GOOD_LAST) begin
                    cond_q <= 1'b0;
                    good_q <= '0;
                end else begin
                    good_q <= good_q + 1'b1;
                end
            end
        end
    end

    assign cond_o = cond_q;
endmodule

// File: rtl/osc_fd_flags.sv
module osc_fd_flags
    import osc_fd_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      ext_cond_i,
    input  logic      int_cond_i,
    input  logic      clr_ext_i,
    input  logic      clr_int_i,
    input  logic      clr_glob_i,
    output fd_flags_t flags_o
);
    fd_flags_t f_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            f_q.ext_f  <= 1'b1;
            f_q.int_f  <= 1'b0;
            f_q.glob_f <= 1'b1;
        end else begin
            f_q.ext_f  <= ext_cond_i | (f_q.ext_f & ~clr_ext_i);
            f_q.int_f  <= int_cond_i | (f_q.int_f & ~clr_int_i);
            f_q.glob_f <= f_q.ext_f | f_q.int_f | (f_q.glob_f & ~clr_glob_i);
        end
    end

    assign flags_o = f_q;
endmodule

// File: rtl/osc_fault_failover.sv
module osc_fault_failover
    import osc_fd_pkg::*;
#(
    parameter int GOOD_CNT = 4096,
    parameter int TMO_W    = 16,
    parameter int N_CONS   = 3
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    ext_clk_i,
    input  logic                    cnt_en_i,
    input  logic [TMO_W-1:0]        timeout_i,
    input  logic                    int_fault_i,
    input  logic                    clr_ext_i,
    input  logic                    clr_int_i,
    input  logic                    clr_glob_i,
    input  logic [N_CONS*SEL_W-1:0] sel_i,
    output logic [N_CONS*SEL_W-1:0] eff_sel_o,
    output logic                    ext_flag_o,
    output logic                    int_flag_o,
    output logic                    glob_flag_o,
    output logic                    irq_o
);
    logic      rise;
    logic      cond;
    logic      fail;
    fd_flags_t flags;

    osc_fd_edge_det u_edge (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i (ext_clk_i),
        .rise_o  (rise)
    );

    osc_fd_monitor #(.GOOD_CNT(GOOD_CNT), .TMO_W(TMO_W)) u_mon (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .rise_i    (rise),
        .cnt_en_i  (cnt_en_i),
        .timeout_i (timeout_i),
        .cond_o    (cond)
    );

    osc_fd_flags u_flags (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .ext_cond_i (cond),
        .int_cond_i (int_fault_i),
        .clr_ext_i  (clr_ext_i),
        .clr_int_i  (clr_int_i),
        .clr_glob_i (clr_glob_i),
        .flags_o    (flags)
    );

    assign fail = flags.ext_f | flags.glob_f;

    for (genvar c = 0; c < N_CONS; c++) begin : g_cons
        assign eff_sel_o[c*SEL_W +: SEL_W] =
            route_src(osc_src_e'(sel_i[c*SEL_W +: SEL_W]), fail);
    end

    assign ext_flag_o  = flags.ext_f;
    assign int_flag_o  = flags.int_f;
    assign glob_flag_o = flags.glob_f;
    assign irq_o       = flags.glob_f;
endmodule

// File: rtl/osc_fd_checker.sv
module osc_fd_checker #(
    parameter int N_CONS = 3
) (
    input logic                clk_i,
    input logic                rst_i,
    input logic                cond,
    input logic                int_fault_i,
    input logic                clr_ext_i,
    input logic                clr_glob_i,
    input logic [N_CONS*2-1:0] sel_i,
    input logic [N_CONS*2-1:0] eff_sel_o,
    input logic                ext_flag_o,
    input logic                int_flag_o,
    input logic                glob_flag_o,
    input logic                irq_o
);
    assert_reset_state_R1: assert property (@(posedge clk_i)
        rst_i |=> (ext_flag_o && glob_flag_o && !int_flag_o));

    assert_ext_sticky_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (ext_flag_o && !clr_ext_i) |=> ext_flag_o);

    assert_int_set_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        int_fault_i |=> int_flag_o);

    assert_glob_follows_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (ext_flag_o || int_flag_o) |=> glob_flag_o);

    assert_glob_sticky_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (glob_flag_o && !clr_glob_i) |=> glob_flag_o);

    assert_fallback_route_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        ((ext_flag_o || glob_flag_o) && sel_i[1:0] == 2'd2) |-> eff_sel_o[1:0] == 2'd0);

    assert_irq_mirror_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o == glob_flag_o);

    assert_clear_loses_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        cond |=> ext_flag_o);
endmodule

bind osc_fault_failover osc_fd_checker #(.N_CONS(N_CONS)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .cond        (cond),
    .int_fault_i (int_fault_i),
    .clr_ext_i   (clr_ext_i),
    .clr_glob_i  (clr_glob_i),
    .sel_i       (sel_i),
    .eff_sel_o   (eff_sel_o),
    .ext_flag_o  (ext_flag_o),
    .int_flag_o  (int_flag_o),
    .glob_flag_o (glob_flag_o),
    .irq_o       (irq_o)
);

// File: tb/osc_fault_failover_tb.sv
module osc_fault_failover_tb_top;
    localparam int GOOD = 8;
    localparam int TW   = 8;
    localparam int NC   = 3;

    logic          clk_i = 1'b0;
    logic          rst_i = 1'b1;
    logic          ext_clk_i = 1'b0;
    logic          cnt_en_i = 1'b1;
    logic [TW-1:0] timeout_i = 8'd20;
    logic          int_fault_i = 1'b0;
    logic          clr_ext_i = 1'b0;
    logic          clr_int_i = 1'b0;
    logic          clr_glob_i = 1'b0;
    logic [NC*2-1:0] sel_i = {2'd2, 2'd1, 2'd2};
    logic [NC*2-1:0] eff_sel_o;
    logic ext_flag_o, int_flag_o, glob_flag_o, irq_o;

    int checks = 0;
    int errors = 0;
    int half = 0;
    int tcnt = 0;
    bit done = 0;

    // behavioural model state
    bit h0, h1, h2;
    int idle, good;
    bit m_cond, m_ext, m_int, m_glob;

    always #5 clk_i = ~clk_i;

    osc_fault_failover #(.GOOD_CNT(GOOD), .TMO_W(TW), .N_CONS(NC)) dut_i (
        .clk_i(clk_i), .rst_i(rst_i), .ext_clk_i(ext_clk_i), .cnt_en_i(cnt_en_i),
        .timeout_i(timeout_i), .int_fault_i(int_fault_i), .clr_ext_i(clr_ext_i),
        .clr_int_i(clr_int_i), .clr_glob_i(clr_glob_i), .sel_i(sel_i),
        .eff_sel_o(eff_sel_o), .ext_flag_o(ext_flag_o), .int_flag_o(int_flag_o),
        .glob_flag_o(glob_flag_o), .irq_o(irq_o)
    );

    always @(posedge clk_i) begin
        bit e, n_ext, n_int, n_glob;
        if (rst_i) begin
            h0 = 0; h1 = 0; h2 = 0; idle = 0; good = 0;
            m_cond = 1; m_ext = 1; m_int = 0; m_glob = 1;
        end else begin
            e = h1 && !h2;
            n_ext  = m_cond || (m_ext && !clr_ext_i);
            n_int  = int_fault_i || (m_int && !clr_int_i);
            n_glob = m_ext || m_int || (m_glob && !clr_glob_i);
            if (!e && idle >= int'(timeout_i)) begin
                m_cond = 1; good = 0; idle = 0;
            end else begin
                idle = e ? 0 : idle + 1;
                if (e && m_cond) begin
                    if (!cnt_en_i || good == GOOD - 1) begin m_cond = 0; good = 0; end
                    else good = good + 1;
                end
            end
            h2 = h1; h1 = h0; h0 = ext_clk_i;
            m_ext = n_ext; m_int = n_int; m_glob = n_glob;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic compare();
        chk(ext_flag_o == m_ext, "R2 ext flag vs model", ext_flag_o, m_ext);
        chk(int_flag_o == m_int, "R6 int flag vs model", int_flag_o, m_int);
        chk(glob_flag_o == m_glob, "R7 global flag vs model", glob_flag_o, m_glob);
        chk(irq_o == m_glob, "R9 irq vs model", irq_o, m_glob);
        for (int i = 0; i < NC; i++) begin
            int req_c, exp_c;
            req_c = int'(sel_i[i*2 +: 2]);
            exp_c = (req_c == 2 && (m_ext || m_glob)) ? 0 : req_c;
            chk(int'(eff_sel_o[i*2 +: 2]) == exp_c, "R8 effective select vs model",
                int'(eff_sel_o[i*2 +: 2]), exp_c);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk_i);
            compare();
            if (half == 0) tcnt = 0;
            else begin
                tcnt++;
                if (tcnt >= half) begin ext_clk_i = ~ext_clk_i; tcnt = 0; end
            end
        end
    endtask

    task automatic pulse_ext();  clr_ext_i = 1;  step(1); clr_ext_i = 0;  endtask
    task automatic pulse_glob(); clr_glob_i = 1; step(1); clr_glob_i = 0; endtask

    initial begin
        repeat (3) @(negedge clk_i);
        chk(ext_flag_o == 1, "R1 ext flag at reset", ext_flag_o, 1);
        chk(glob_flag_o == 1, "R1 global flag at reset", glob_flag_o, 1);
        chk(int_flag_o == 0, "R1 int flag at reset", int_flag_o, 0);
        chk(eff_sel_o[1:0] == 2'd0, "R1 fallback at reset", eff_sel_o[1:0], 0);
        rst_i = 0;

        // slow external clock, clear attempt while condition is present
        half = 2;
        step(10);
        pulse_ext();
        step(1);
        chk(ext_flag_o == 1, "R2 clear ignored during fault", ext_flag_o, 1);
        step(60);
        chk(ext_flag_o == 1, "R2 flag stays after condition ends", ext_flag_o, 1);
        chk(irq_o == 1, "R9 no event on fault end", irq_o, 1);
        pulse_ext();
        step(1);
        chk(ext_flag_o == 0, "R2 clear accepted", ext_flag_o, 0);
        chk(glob_flag_o == 1, "R7 global still set", glob_flag_o, 1);
        chk(eff_sel_o[1:0] == 2'd0, "R8 fallback while global set", eff_sel_o[1:0], 0);
        pulse_glob();
        step(1);
        chk(glob_flag_o == 0, "R7 global cleared", glob_flag_o, 0);
        chk(eff_sel_o[1:0] == 2'd2, "R8 external restored", eff_sel_o[1:0], 2);
        chk(eff_sel_o[3:2] == 2'd1, "R8 pass-through code", eff_sel_o[3:2], 1);

        // stopped clock trips timeout
        half = 0;
        step(40);
        chk(ext_flag_o == 1, "R4 timeout sets flag", ext_flag_o, 1);
        chk(eff_sel_o[5:4] == 2'd0, "R4 failover after timeout", eff_sel_o[5:4], 0);

        // fast external clock qualifies quickly
        half = 1;
        step(22);
        pulse_ext();
        step(1);
        chk(ext_flag_o == 0, "R3 fast clock qualified", ext_flag_o, 0);
        pulse_ext(); pulse_glob();
        step(1);

        // clear held across a new fault event
        clr_ext_i = 1;
        half = 0;
        step(40);
        clr_ext_i = 0;
        chk(ext_flag_o == 1, "R10 clear loses to new fault", ext_flag_o, 1);

        // count check disabled
        cnt_en_i = 0;
        half = 3;
        step(12);
        pulse_ext();
        step(1);
        chk(ext_flag_o == 0, "R5 single edge accepted", ext_flag_o, 0);
        pulse_glob();
        step(1);
        chk(glob_flag_o == 0, "R7 global cleared after R5", glob_flag_o, 0);
        cnt_en_i = 1;

        // internal fault path
        int_fault_i = 1; step(1); int_fault_i = 0;
        step(1);
        chk(int_flag_o == 1, "R6 int flag set", int_flag_o, 1);
        chk(glob_flag_o == 1, "R7 global follows int", glob_flag_o, 1);
        clr_int_i = 1; clr_glob_i = 1; step(1); clr_int_i = 0; clr_glob_i = 0;
        step(1);
        chk(int_flag_o == 0, "R6 int flag cleared", int_flag_o, 0);
        chk(glob_flag_o == 1, "R7 global clear blocked", glob_flag_o, 1);
        pulse_glob();
        step(2);
        chk(glob_flag_o == 0, "R7 global cleared last", glob_flag_o, 0);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk_i);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule